// File: doc/BRIEF.md
# Overlapping Register Window File

This block is the general-purpose register file of a RISC core that gives every procedure activation its own window of registers. A core sees 32 architectural registers. A small shared bank is visible from every window. Each window also has private input, local and output groups. The output group of one window and the input group of the next window are the same physical storage, so a caller hands arguments to its callee by writing its output registers, and no data is copied. A circular current-window pointer turns each architectural register number into a physical storage index. The pointer steps forward on a call and back on a return.

The physical storage holds `NWIN` windows. Because the newest window's output group occupies part of the following window, at most `NWIN-1` activations can be resident at once. A call made with `NWIN-1` activations resident is an overflow. The block then sends the oldest window out over a spill port, one word per handshake, and completes the call once that window is out. A return made with a single resident activation is an underflow. The block then steps back at once and accepts that window's contents over a fill port. Only the input and local groups travel over these ports, because the output group of a window belongs to its neighbour. The handler that stores the words and the save area in memory lie outside this block.

Top module: `rwin_file`

## Requirements
- R1: Architectural registers 0 to 7 form one shared bank. A value written to one of them from any window reads back unchanged from every other window.
- R2: Registers 16 to 23 (locals) are private to their window. A write to a local in a callee leaves the caller's local of the same number unchanged after the return.
- R3: A call steps `cwp_o` forward by one, modulo `NWIN`, and a return steps it back by one. After a call, the callee's registers 8+i (inputs) read the values the caller wrote to 24+i (outputs), for i from 0 to 7. After the return, the caller reads its locals and outputs unchanged.
- R4: Both read ports are combinational. The write port updates storage at the rising clock edge, so a read of the register being written returns the old value before that edge and the new value after it.
- R5: When `call_i` and `ret_i` are asserted in the same cycle, the call is performed and the return is ignored.
- R6: A call made while `NWIN-1` activations are resident raises `spill_valid`. The block then sends 16 words of the oldest resident window: words 0 to 7 are its inputs (registers 8 to 15, in that order) and words 8 to 15 are its locals (registers 16 to 23). The output group is not sent.
- R7: A spill word is consumed only in a cycle where `spill_ready` is high. `cwp_o` holds its value until the 16th word is consumed, and then advances to complete the pending call.
- R8: A return made while one activation is resident moves `cwp_o` back one step at the next edge and raises `fill_ready`. The 16 words accepted while `fill_valid` is high are written into that window's inputs (words 0 to 7) and then its locals (words 8 to 15). Afterwards its inputs, locals and outputs read as they were before the window was spilled.
- R9: While a spill or fill is in progress (`busy_o` high), `call_i`, `ret_i` and `wr_en` have no effect. The read ports keep working.
- R10: After a synchronous active-high reset, `cwp_o` is 0, `busy_o`, `spill_valid` and `fill_ready` are low, and one activation is resident.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_i | input | 1 | Procedure call: advance the window |
| ret_i | input | 1 | Procedure return: retreat the window |
| ra_idx | input | 5 | Read port A architectural register number |
| ra_data | output | 32 | Read port A data (combinational) |
| rb_idx | input | 5 | Read port B architectural register number |
| rb_data | output | 32 | Read port B data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write architectural register number |
| wr_data | input | 32 | Write data |
| cwp_o | output | $clog2(NWIN) | Current window pointer |
| busy_o | output | 1 | A spill or fill is in progress |
| spill_valid | output | 1 | Overflow: a spill word is offered |
| spill_ready | input | 1 | Consumer accepts the spill word |
| spill_data | output | 32 | Spill word |
| fill_valid | input | 1 | Producer offers a fill word |
| fill_ready | output | 1 | Underflow: the block accepts fill words |
| fill_data | input | 32 | Fill word |

## Verification
The bench builds the block with the default of eight windows. A nine-level call chain therefore reaches beyond the seven resident activations and forces two back-to-back spills, and the window pointer wraps from 7 back to 0. Unwinding the chain then forces two fills, so spilled windows are restored and read back against values computed from their level number. Spill and fill words arrive with gaps in the handshake. One spill stall cycle carries a call, a return and a write at the same time, and none of them may take effect.

// File: rtl/rwin_pkg.sv
`timescale 1ns/1ps
package rwin_pkg;
    // architectural register space: four groups of eight
    localparam int AREG_W  = 5;
    localparam int GRP_SZ  = 8;
    localparam int GIDX_W  = $clog2(GRP_SZ);
    // a window owns its input and local groups
    localparam int SLOT_SZ = 2 * GRP_SZ;
    localparam int OFF_W   = $clog2(SLOT_SZ);

    typedef enum logic [1:0] {
        GRP_GLOB = 2'd0,
        GRP_IN   = 2'd1,
        GRP_LOC  = 2'd2,
        GRP_OUT  = 2'd3
    } grp_e;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SPILL = 2'd1,
        ST_FILL  = 2'd2
    } xfer_e;

    function automatic grp_e grp_of(input logic [AREG_W-1:0] a);
        return grp_e'(a[AREG_W-1:GIDX_W]);
    endfunction
endpackage

// File: rtl/rwin_map.sv
`timescale 1ns/1ps
module rwin_map
    import rwin_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int CW = $clog2(NWIN),
    localparam int PW = $clog2(NWIN * SLOT_SZ)
) (
    input  logic [AREG_W-1:0] areg,
    input  logic [CW-1:0]     cwp,
    output logic              is_glob,
    output logic [GIDX_W-1:0] gidx,
    output logic [PW-1:0]     pidx
);
    grp_e             grp;
    logic [CW-1:0]    win;
    logic [OFF_W-1:0] off;

    always_comb begin
        grp     = grp_of(areg);
        is_glob = (grp == GRP_GLOB);
        gidx    = areg[GIDX_W-1:0];
        // outputs live in the next window's input slot
        if (grp == GRP_OUT)
            win = (cwp == CW'(NWIN - 1)) ? '0 : cwp + CW'(1);
        else
            win = cwp;
        off  = {(grp == GRP_LOC), areg[GIDX_W-1:0]};
        pidx = PW'(win) * PW'(SLOT_SZ) + PW'(off);
    end
endmodule

// File: rtl/rwin_store.sv
`timescale 1ns/1ps
module rwin_store
    import rwin_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int DW   = 32,
    localparam int PW  = $clog2(NWIN * SLOT_SZ),
    localparam int NPHY = NWIN * SLOT_SZ
) (
    input  logic              clk,
    input  logic              we,
    input  logic              w_glob,
    input  logic [GIDX_W-1:0] w_gidx,
    input  logic [PW-1:0]     w_pidx,
    input  logic [DW-1:0]     w_data,
    input  logic              a_glob,
    input  logic [GIDX_W-1:0] a_gidx,
    input  logic [PW-1:0]     a_pidx,
    output logic [DW-1:0]     a_data,
    input  logic              b_glob,
    input  logic [GIDX_W-1:0] b_gidx,
    input  logic [PW-1:0]     b_pidx,
    output logic [DW-1:0]     b_data,
    input  logic [PW-1:0]     s_pidx,
    output logic [DW-1:0]     s_data
);
    logic [DW-1:0] gbank [GRP_SZ];
    logic [DW-1:0] wbank [NPHY];

    always_ff @(posedge clk) begin
        if (we) begin
            if (w_glob) gbank[w_gidx] <= w_data;
            else        wbank[w_pidx] <= w_data;
        end
    end

    assign a_data = a_glob ? gbank[a_gidx] : wbank[a_pidx];
    assign b_data = b_glob ? gbank[b_gidx] : wbank[b_pidx];
    assign s_data = wbank[s_pidx];
endmodule

// File: rtl/rwin_ctrl.sv
`timescale 1ns/1ps
module rwin_ctrl
    import rwin_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int CW = $clog2(NWIN),
    localparam int RW = $clog2(NWIN + 1),
    localparam int PW = $clog2(NWIN * SLOT_SZ)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          call_i,
    input  logic          ret_i,
    input  logic          spill_ready,
    input  logic          fill_valid,
    output logic [CW-1:0] cwp,
    output logic          busy,
    output logic          spill_valid,
    output logic          fill_ready,
    output logic [PW-1:0] xfer_pidx
);
    xfer_e            st;
    logic [CW-1:0]    swp;
    logic [RW-1:0]    res;
    logic [OFF_W-1:0] cnt;
    logic             last;

    function automatic logic [CW-1:0] wnext(input logic [CW-1:0] w);
        return (w == CW'(NWIN - 1)) ? '0 : w + CW'(1);
    endfunction
    function automatic logic [CW-1:0] wprev(input logic [CW-1:0] w);
        return (w == '0) ? CW'(NWIN - 1) : w - CW'(1);
    endfunction

    assign last = (cnt == OFF_W'(SLOT_SZ - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_RUN;
            cwp <= '0;
            swp <= '0;
            res <= RW'(1);
            cnt <= '0;
        end else begin
            unique case (st)
                ST_RUN: begin
                    if (call_i) begin
                        if (res == RW'(NWIN - 1)) begin
                            st  <= ST_SPILL;
                            cnt <= '0;
                        end else begin
                            cwp <= wnext(cwp);
                            res <= res + RW'(1);
                        end
                    end else if (ret_i) begin
                        cwp <= wprev(cwp);
                        if (res == RW'(1)) begin
                            swp <= wprev(swp);
                            st  <= ST_FILL;
                            cnt <= '0;
                        end else begin
                            res <= res - RW'(1);
                        end
                    end
                end
                ST_SPILL: begin
                    if (spill_ready) begin
                        cnt <= cnt + OFF_W'(1);
                        if (last) begin
                            swp <= wnext(swp);
                            cwp <= wnext(cwp);
                            st  <= ST_RUN;
                        end
                    end
                end
                ST_FILL: begin
                    if (fill_valid) begin
                        cnt <= cnt + OFF_W'(1);
                        if (last) st <= ST_RUN;
                    end
                end
                default: st <= ST_RUN;
            endcase
        end
    end

    assign spill_valid = (st == ST_SPILL);
    assign fill_ready  = (st == ST_FILL);
    assign busy        = (st != ST_RUN);
    assign xfer_pidx   = PW'(swp) * PW'(SLOT_SZ) + PW'(cnt);

    // distance from oldest resident window to current one
    logic [CW:0] span;
    always_comb begin
        if (cwp >= swp) span = {1'b0, cwp} - {1'b0, swp};
        else            span = {1'b0, cwp} + (CW+1)'(NWIN) - {1'b0, swp};
    end

    assert_res_bound_R6: assert property (@(posedge clk) disable iff (rst)
        (res >= RW'(1)) && (res <= RW'(NWIN - 1)));

    assert_span_R6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN) |-> ((RW'(span) + RW'(1)) == res));

    assert_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN && call_i && res == RW'(NWIN - 1)) |=> (st == ST_SPILL && cnt == '0));

    assert_spill_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SPILL && !spill_ready) |=> (st == ST_SPILL && $stable(cnt) && $stable(cwp)));

    assert_spill_done_R7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SPILL && spill_ready && last) |=> (st == ST_RUN && cwp == wnext($past(cwp))));

    assert_underflow_R8: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN && !call_i && ret_i && res == RW'(1)) |=> (st == ST_FILL && cwp == wprev($past(cwp))));

    assert_call_wins_R5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN && call_i && ret_i && res != RW'(NWIN - 1)) |=> (cwp == wnext($past(cwp))));

    assert_fill_still_R9: assert property (@(posedge clk) disable iff (rst)
        (st == ST_FILL) |=> $stable(cwp));

    assert_reset_R10: assert property (@(posedge clk)
        rst |=> (cwp == '0 && st == ST_RUN && res == RW'(1)));
endmodule

// File: rtl/rwin_file.sv
`timescale 1ns/1ps
module rwin_file
    import rwin_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int DW   = 32,
    localparam int CW  = $clog2(NWIN),
    localparam int PW  = $clog2(NWIN * SLOT_SZ)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              call_i,
    input  logic              ret_i,
    input  logic [AREG_W-1:0] ra_idx,
    output logic [DW-1:0]     ra_data,
    input  logic [AREG_W-1:0] rb_idx,
    output logic [DW-1:0]     rb_data,
    input  logic              wr_en,
    input  logic [AREG_W-1:0] wr_idx,
    input  logic [DW-1:0]     wr_data,
    output logic [CW-1:0]     cwp_o,
    output logic              busy_o,
    output logic              spill_valid,
    input  logic              spill_ready,
    output logic [DW-1:0]     spill_data,
    input  logic              fill_valid,
    output logic              fill_ready,
    input  logic [DW-1:0]     fill_data
);
    localparam int NPORT = 3;   // read A, read B, write

    logic [CW-1:0]     cwp;
    logic              busy;
    logic [PW-1:0]     xfer_pidx;
    logic [AREG_W-1:0] m_areg [NPORT];
    logic              m_glob [NPORT];
    logic [GIDX_W-1:0] m_gidx [NPORT];
    logic [PW-1:0]     m_pidx [NPORT];

    assign m_areg[0] = ra_idx;
    assign m_areg[1] = rb_idx;
    assign m_areg[2] = wr_idx;

    rwin_ctrl #(.NWIN(NWIN)) u_ctrl (
        .clk(clk), .rst(rst), .call_i(call_i), .ret_i(ret_i),
        .spill_ready(spill_ready), .fill_valid(fill_valid),
        .cwp(cwp), .busy(busy), .spill_valid(spill_valid),
        .fill_ready(fill_ready), .xfer_pidx(xfer_pidx)
    );

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_map
            rwin_map #(.NWIN(NWIN)) u_map (
                .areg(m_areg[p]), .cwp(cwp), .is_glob(m_glob[p]),
                .gidx(m_gidx[p]), .pidx(m_pidx[p])
            );
        end
    endgenerate

    // fill traffic owns the write port during an underflow
    logic              w_en;
    logic              w_glob;
    logic [GIDX_W-1:0] w_gidx;
    logic [PW-1:0]     w_pidx;
    logic [DW-1:0]     w_data;

    always_comb begin
        if (fill_ready) begin
            w_en   = fill_valid;
            w_glob = 1'b0;
            w_gidx = '0;
            w_pidx = xfer_pidx;
            w_data = fill_data;
        end else begin
            w_en   = wr_en && !busy;
            w_glob = m_glob[2];
            w_gidx = m_gidx[2];
            w_pidx = m_pidx[2];
            w_data = wr_data;
        end
    end

    rwin_store #(.NWIN(NWIN), .DW(DW)) u_store (
        .clk(clk), .we(w_en), .w_glob(w_glob), .w_gidx(w_gidx),
        .w_pidx(w_pidx), .w_data(w_data),
        .a_glob(m_glob[0]), .a_gidx(m_gidx[0]), .a_pidx(m_pidx[0]), .a_data(ra_data),
        .b_glob(m_glob[1]), .b_gidx(m_gidx[1]), .b_pidx(m_pidx[1]), .b_data(rb_data),
        .s_pidx(xfer_pidx), .s_data(spill_data)
    );

    assign cwp_o  = cwp;
    assign busy_o = busy;

    assert_one_xfer_R9: assert property (@(posedge clk) disable iff (rst)
        !(spill_valid && fill_ready));
endmodule

// File: tb/rwin_file_test.sv
`timescale 1ns/1ps
module rwin_file_test;
    localparam int NWIN = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        call_i, ret_i, wr_en, spill_ready, fill_valid;
    logic [4:0]  ra_idx, rb_idx, wr_idx;
    logic [31:0] ra_data, rb_data, wr_data, spill_data, fill_data;
    logic [2:0]  cwp_o;
    logic        busy_o, spill_valid, fill_ready;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [31:0] saved [2][16];

    always #5 clk = ~clk;

    rwin_file #(.NWIN(NWIN)) uut (
        .clk(clk), .rst(rst), .call_i(call_i), .ret_i(ret_i),
        .ra_idx(ra_idx), .ra_data(ra_data), .rb_idx(rb_idx), .rb_data(rb_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .cwp_o(cwp_o), .busy_o(busy_o),
        .spill_valid(spill_valid), .spill_ready(spill_ready), .spill_data(spill_data),
        .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_data(fill_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] loc_v(input int k, input int i);
        return 32'hA000_0000 | (k << 8) | i;
    endfunction
    function automatic logic [31:0] out_v(input int k, input int i);
        return 32'hB000_0000 | (k << 8) | i;
    endfunction
    function automatic logic [31:0] in_v(input int k, input int i);
        return (k == 0) ? (32'hC000_0000 | i) : out_v(k - 1, i);
    endfunction

    task automatic do_reset();
        rst = 1'b1; call_i = 0; ret_i = 0; wr_en = 0; spill_ready = 0; fill_valid = 0;
        ra_idx = 0; rb_idx = 0; wr_idx = 0; wr_data = 0; fill_data = 0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 5'(idx); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input int idx, input logic [31:0] exp);
        @(negedge clk);
        ra_idx = 5'(idx);
        #1;
        chk(tag, ra_data, exp);
    endtask

    task automatic pulse(input bit c, input bit r);
        @(negedge clk);
        call_i = c; ret_i = r;
        @(negedge clk);
        call_i = 0; ret_i = 0;
    endtask

    // collects one spilled window; called at the negedge after the overflowing call
    task automatic spill_collect(input int lvl, input int slot, input int cwp_after, input bit poke);
        int n = 0;
        int cyc = 0;
        logic [2:0] cw0 = cwp_o;
        chk("R6 spill_valid on overflow", 32'(spill_valid), 32'd1);
        while (n < 16) begin
            spill_ready = (cyc % 3 != 1);
            if (poke && cyc == 1) begin
                call_i = 1; ret_i = 1; wr_en = 1; wr_idx = 5'd1; wr_data = 32'hDEAD_0001;
            end else begin
                call_i = 0; ret_i = 0; wr_en = 0;
            end
            #1;
            if (cyc == 1) chk("R7 cwp held during spill", 32'(cwp_o), 32'(cw0));
            if (spill_ready) begin
                chk("R6 spill word", spill_data, (n < 8) ? in_v(lvl, n) : loc_v(lvl, n - 8));
                saved[slot][n] = spill_data;
                n++;
            end
            cyc++;
            @(negedge clk);
        end
        spill_ready = 0; call_i = 0; ret_i = 0; wr_en = 0;
        chk("R7 cwp after spill", 32'(cwp_o), 32'(cwp_after));
        chk("R7 spill_valid drops", 32'(spill_valid), 32'd0);
    endtask

    // supplies one window; called at the negedge after the underflowing return
    task automatic fill_supply(input int slot, input int cwp_exp);
        int n = 0;
        int cyc = 0;
        chk("R8 fill_ready on underflow", 32'(fill_ready), 32'd1);
        chk("R8 cwp retreats at once", 32'(cwp_o), 32'(cwp_exp));
        while (n < 16) begin
            fill_valid = (cyc % 2 == 0);
            fill_data  = fill_valid ? saved[slot][n] : 32'hFFFF_FFFF;
            #1;
            if (fill_valid) n++;
            cyc++;
            @(negedge clk);
        end
        fill_valid = 0;
        chk("R8 fill_ready drops", 32'(fill_ready), 32'd0);
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        chk("R10 cwp after reset", 32'(cwp_o), 32'd0);
        chk("R10 busy after reset", 32'(busy_o), 32'd0);
        chk("R10 spill_valid after reset", 32'(spill_valid), 32'd0);
        chk("R10 fill_ready after reset", 32'(fill_ready), 32'd0);
    endtask

    task automatic t_window();
        wr(3, 32'h0000_0333);
        wr(16, 32'h1600_0000);
        wr(24, 32'h2400_0000);
        wr(31, 32'h3100_0000);
        pulse(1, 0);
        chk("R3 cwp after call", 32'(cwp_o), 32'd1);
        rd_chk("R1 global seen by callee", 3, 32'h0000_0333);
        rd_chk("R3 callee input 8", 8, 32'h2400_0000);
        rd_chk("R3 callee input 15", 15, 32'h3100_0000);
        wr(16, 32'h1600_0001);
        wr(3, 32'h0000_0444);
        pulse(0, 1);
        chk("R3 cwp after return", 32'(cwp_o), 32'd0);
        rd_chk("R2 caller local kept", 16, 32'h1600_0000);
        rd_chk("R1 global written by callee", 3, 32'h0000_0444);
    endtask

    task automatic t_rw();
        wr(5, 32'h0505_0505);
        @(negedge clk);
        rb_idx = 5'd5; wr_en = 1; wr_idx = 5'd5; wr_data = 32'h5A5A_5A5A;
        #1;
        chk("R4 old value before edge", rb_data, 32'h0505_0505);
        @(negedge clk);
        wr_en = 0;
        #1;
        chk("R4 new value after edge", rb_data, 32'h5A5A_5A5A);
    endtask

    task automatic t_both();
        pulse(1, 1);
        chk("R5 call wins over return", 32'(cwp_o), 32'd1);
        chk("R5 no fill on simultaneous", 32'(fill_ready), 32'd0);
        pulse(0, 1);
        chk("R5 return afterwards", 32'(cwp_o), 32'd0);
    endtask

    task automatic t_deep();
        do_reset();
        wr(1, 32'h0000_1111);
        for (int i = 0; i < 8; i++) wr(8 + i, in_v(0, i));
        for (int lvl = 0; lvl <= 8; lvl++) begin
            for (int i = 0; i < 8; i++) begin
                wr(16 + i, loc_v(lvl, i));
                wr(24 + i, out_v(lvl, i));
            end
            if (lvl < 8) begin
                pulse(1, 0);
                if (lvl + 1 >= 7) spill_collect(lvl - 6, lvl - 6, (lvl + 1) % NWIN, lvl == 6);
                chk("R3 cwp in chain", 32'(cwp_o), 32'((lvl + 1) % NWIN));
                for (int i = 0; i < 8; i++) rd_chk("R3 args in chain", 8 + i, in_v(lvl + 1, i));
                if (lvl == 6) rd_chk("R9 write during spill ignored", 1, 32'h0000_1111);
            end
        end
        for (int lvl = 8; lvl >= 1; lvl--) begin
            pulse(0, 1);
            if (lvl - 1 <= 1) fill_supply(lvl - 1, lvl - 1);
            chk("R3 cwp unwinding", 32'(cwp_o), 32'((lvl - 1) % NWIN));
            for (int i = 0; i < 8; i++) begin
                rd_chk("R8 inputs after return", 8 + i, in_v(lvl - 1, i));
                rd_chk("R8 locals after return", 16 + i, loc_v(lvl - 1, i));
                rd_chk("R8 outputs after return", 24 + i, out_v(lvl - 1, i));
            end
        end
        rd_chk("R1 global after deep chain", 1, 32'h0000_1111);
    endtask

    initial begin
        t_reset();
        t_window();
        t_rw();
        t_both();
        t_deep();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule